// File: doc/BRIEF.md
# Burst Address-Phase Sequencer

This block sits on the manager side of an AHB-Lite bus and drives the address phase of each transfer in a burst. A request gives a start address, a burst type and a transfer size. From that request the block produces, beat by beat, the bus address, the transfer type, the burst code and the size. It supports single transfers, fixed-length incrementing and wrapping bursts of 4, 8 and 16 beats, and incrementing bursts of open length that end on a stop input. Data movement and arbitration are handled by other logic.

Every output is a register. The block moves forward only on a clock edge where `hready` is high. A manager that cannot continue in the middle of a burst raises `stall`, and the block then shows BUSY cycles. During those cycles the address and control already show the next beat, which has not been issued yet. When a burst ends, the bus returns to IDLE and `done` pulses for one cycle.

Top module: `ahb_burst_addr_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `htrans` is IDLE (00), `haddr`, `hburst` and `hsize` are zero, and `done` is low.
- R2: A `start` seen on an edge where `htrans` is IDLE and `hready` is high makes the next cycle a NONSEQ (10) beat at `start_addr`, carrying `burst_type` and `xfer_size`. A `start` seen while a burst is in progress, or while `hready` is low, has no effect.
- R3: For the incrementing codes 001, 011, 101 and 111, the address of each beat after the first is the previous beat's address plus 2^`hsize` bytes.
- R4: For the wrapping codes 010, 100 and 110, the block size is the beat count times 2^`hsize`. The address bits above that block size are kept, and the bits below it step by 2^`hsize` modulo the block size.
- R5: A fixed-length burst issues exactly as many NONSEQ/SEQ beats as its code gives: 000 gives 1, 010 and 011 give 4, 100 and 101 give 8, 110 and 111 give 16.
- R6: An open-length burst (code 001) goes on until a beat is accepted while `stop` is high. That beat is the last one. `stop` has no effect on other burst types.
- R7: The first beat of a burst is NONSEQ and every later beat is SEQ (11). `hburst` and `hsize` stay constant from the first beat to the return to IDLE.
- R8: When a beat is accepted, more beats remain and `stall` is high, the next cycle is BUSY (01) with the next beat's address. BUSY repeats while `stall` is high at a ready edge, changes to SEQ when `stall` is low, and never counts as a beat. `stall` is ignored when the accepted beat is the last one and while the bus is idle.
- R9: On an edge where `hready` is low, `haddr`, `htrans`, `hburst` and `hsize` keep their values.
- R10: When the last beat of a burst is accepted, the next cycle shows IDLE with `done` high. `done` is high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burst |
| start_addr | input | ADDR_W | Address of the first beat, aligned to the transfer size |
| burst_type | input | 3 | Burst code for the new burst |
| xfer_size | input | 3 | log2 of the transfer size in bytes |
| stall | input | 1 | Manager cannot continue; insert BUSY |
| stop | input | 1 | End an open-length burst at the beat being accepted |
| hready | input | 1 | Bus ready; the block advances only when this is high |
| haddr | output | ADDR_W | Address-phase address |
| htrans | output | 2 | Transfer type: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| hburst | output | 3 | Burst code of the current burst |
| hsize | output | 3 | Transfer size of the current burst |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
The assertions assume that `start_addr` is aligned to the transfer size it is given with, and that the address space is large enough for a wrapping block of up to 16 × 128 bytes. The stimulus clears the low address bits to match each randomly chosen size. It mostly uses sizes up to 8 bytes, with the occasional largest size, so that every wrapping block size is exercised. All inputs, including `start`, `stall` and `stop`, are driven at random in every cycle, even while `hready` is low. This is done because the block must ignore them then, and the reference model checks that it does.

// File: rtl/ahb_burst_addr_gen.sv
module ahb_burst_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        burst_type,
  input  logic [2:0]        xfer_size,
  input  logic              stall,
  input  logic              stop,
  input  logic              hready,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic [2:0]        hburst,
  output logic [2:0]        hsize,
  output logic              done
);
  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_BUSY = 2'b01;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;
  localparam logic [2:0] BT_INCR = 3'b001;

  logic [CNT_W-1:0]  beats_acc, burst_len;
  logic [3:0]        wrap_lg;
  logic              is_wrap, last_beat, accept_beat;
  logic [ADDR_W-1:0] step, incr_addr, wrap_mask, next_addr;

  always_comb begin
    case (hburst)
      3'b000:          burst_len = CNT_W'(1);
      3'b010, 3'b011:  burst_len = CNT_W'(4);
      3'b100, 3'b101:  burst_len = CNT_W'(8);
      3'b110, 3'b111:  burst_len = CNT_W'(16);
      default:         burst_len = '0;
    endcase
  end

  assign accept_beat = hready && htrans[1];
  assign is_wrap     = !hburst[0] && (hburst[2:1] != 2'b00);
  assign wrap_lg     = 4'(hsize) + 4'(hburst[2:1]) + 4'd1;
  assign step        = ADDR_W'(1) << hsize;
  assign incr_addr   = haddr + step;
  assign wrap_mask   = (ADDR_W'(1) << wrap_lg) - ADDR_W'(1);
  assign next_addr   = is_wrap ? ((haddr & ~wrap_mask) | (incr_addr & wrap_mask)) : incr_addr;
  assign last_beat   = (hburst == BT_INCR) ? stop : (beats_acc + CNT_W'(1) == burst_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haddr     <= '0;
      htrans    <= TR_IDLE;
      hburst    <= '0;
      hsize     <= '0;
      beats_acc <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (hready) begin
        case (htrans)
          TR_IDLE: if (start) begin
            haddr     <= start_addr;
            hburst    <= burst_type;
            hsize     <= xfer_size;
            htrans    <= TR_NSEQ;
            beats_acc <= '0;
          end
          TR_BUSY: htrans <= stall ? TR_BUSY : TR_SEQ;
          default: if (last_beat) begin
            htrans <= TR_IDLE;
            done   <= 1'b1;
          end else begin
            haddr     <= next_addr;
            htrans    <= stall ? TR_BUSY : TR_SEQ;
            beats_acc <= beats_acc + CNT_W'(1);
          end
        endcase
      end
    end
  end

  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> ($stable(haddr) && $stable(htrans) && $stable(hburst) && $stable(hsize))); // R9
  AST_FIRST_NONSEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == TR_IDLE) |=> (htrans == TR_IDLE || htrans == TR_NSEQ)); // R7
  AST_CTRL_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != TR_IDLE) |=> (htrans == TR_IDLE || ($stable(hsize) && $stable(hburst)))); // R7
  AST_INCR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_beat && hburst[0] && !last_beat) |=> (haddr == $past(haddr) + (ADDR_W'(1) << $past(hsize)))); // R3
  AST_WRAP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_beat && is_wrap && !last_beat) |=> ((haddr & ~$past(wrap_mask)) == ($past(haddr) & ~$past(wrap_mask)))); // R4
  AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != TR_IDLE && hburst != BT_INCR) |-> (beats_acc < burst_len)); // R5
  AST_NO_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == TR_BUSY) |-> (hburst != 3'b000)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (htrans == TR_IDLE)); // R10
endmodule

// File: tb/ahb_burst_addr_gen_test.sv
module ahb_burst_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stall = 1'b0, stop = 1'b0, hready = 1'b0;
  logic [31:0] start_addr = '0;
  logic [2:0]  burst_type = '0, xfer_size = '0;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic [2:0]  hburst, hsize;
  logic        done;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ahb_burst_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .burst_type(burst_type), .xfer_size(xfer_size), .stall(stall), .stop(stop),
    .hready(hready), .haddr(haddr), .htrans(htrans), .hburst(hburst),
    .hsize(hsize), .done(done)
  );

  logic [31:0] m_addr;
  logic [1:0]  m_trans;
  logic [2:0]  m_burst, m_size;
  logic        m_done;
  int          m_count;
  string       m_tag;

  function automatic int beats_of(input logic [2:0] b);
    case (b)
      3'd0: return 1;
      3'd2, 3'd3: return 4;
      3'd4, 3'd5: return 8;
      3'd6, 3'd7: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] follow(input logic [31:0] a, input logic [2:0] b, input logic [2:0] s);
    logic [31:0] bytes, blk, off;
    bytes = 32'd1 << s;
    if (b[0] || b == 3'd0) return a + bytes;
    blk = bytes * 32'(beats_of(b));
    off = a % blk;
    return (a - off) + ((off + bytes) % blk);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr <= '0; m_trans <= 2'b00; m_burst <= '0; m_size <= '0;
      m_done <= 1'b0; m_count <= 0; m_tag <= "R1";
    end else begin
      m_done <= 1'b0;
      if (!hready) m_tag <= "R9";
      else if (m_trans == 2'b00) begin
        m_tag <= "R2";
        if (start) begin
          m_addr <= start_addr; m_burst <= burst_type; m_size <= xfer_size;
          m_trans <= 2'b10; m_count <= 0;
        end
      end else if (m_trans == 2'b01) begin
        m_tag <= "R8";
        m_trans <= stall ? 2'b01 : 2'b11;
      end else begin
        if (m_burst == 3'd1 ? stop : (m_count + 1 == beats_of(m_burst))) begin
          m_trans <= 2'b00; m_done <= 1'b1;
          m_tag <= (m_burst == 3'd1) ? "R6" : "R5";
        end else begin
          m_addr <= follow(m_addr, m_burst, m_size);
          m_trans <= stall ? 2'b01 : 2'b11;
          m_count <= m_count + 1;
          m_tag <= stall ? "R8" : ((m_burst[0]) ? "R3" : "R4");
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      check({m_tag, " haddr"}, haddr, m_addr);
      check({m_tag, " htrans"}, 32'(htrans), 32'(m_trans));
      check("R7 hburst", 32'(hburst), 32'(m_burst));
      check("R7 hsize", 32'(hsize), 32'(m_size));
      check("R10 done", 32'(done), 32'(m_done));
    end
    if (cycles > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] wrap_exp [4];
    wrap_exp[0] = 32'h38; wrap_exp[1] = 32'h3C; wrap_exp[2] = 32'h30; wrap_exp[3] = 32'h34;
    repeat (3) @(negedge clk);
    check("R1 htrans", 32'(htrans), 32'd0);
    check("R1 haddr", haddr, 32'd0);
    check("R1 done", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'(htrans), 32'd0);
    hready = 1'b1; start = 1'b1; burst_type = 3'b010; xfer_size = 3'd2; start_addr = 32'h38;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R4 wrap4 addr", haddr, wrap_exp[i]);
      check("R7 nonseq then seq", 32'(htrans), (i == 0) ? 32'd2 : 32'd3);
      @(negedge clk);
    end
    check("R10 done after wrap4", 32'(done), 32'd1);
    check("R10 idle after wrap4", 32'(htrans), 32'd0);
    for (int n = 0; n < 6000; n++) begin
      logic [2:0] sz;
      hready = ($urandom % 4) != 0;
      stall  = ($urandom % 4) == 0;
      stop   = ($urandom % 5) == 0;
      start  = ($urandom % 3) == 0;
      burst_type = 3'($urandom % 8);
      sz = ($urandom % 10 == 0) ? 3'($urandom % 8) : 3'($urandom % 4);
      xfer_size = sz;
      start_addr = $urandom & ~((32'd1 << sz) - 32'd1);
      @(negedge clk);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule